// File: doc/BRIEF.md
# Wrapping Burst Line Refill Controller

This block refills one data-cache line of 32 bytes, which is eight 32-bit words aligned to a 32-byte boundary. A requester presents the missing byte address on a valid/ready handshake. The block then issues one burst read on a 64-bit bus. The burst begins at the double word that holds the missing address. The bus returns four beats, and their order wraps around the line.

Each accepted beat goes out on the cache data write port in the cycle it arrives. A local line buffer also keeps a copy of each beat. The first beat is the critical one. In the cycle it is written, it is also handed to the requester with a strobe. A busy flag holds off new cache accesses from the moment the miss is taken until the fill ends. After the fourth beat there is a one-cycle completion pulse. During that pulse the assembled line is presented in address order. Busy clears on the following cycle.

Back-pressure rules:
- The miss channel is ready only while no fill is active.
- The burst request holds its valid and address until the bus accepts it.
- The beat channel is ready only between request acceptance and the fourth beat. The bus may pause for any number of cycles between beats.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, busy, bus_req_valid, beat_ready, wr_en, crit_valid and fill_done are low, and miss_ready is high.
- R2: A miss is taken only in a cycle where miss_valid and miss_ready are both high. miss_ready equals the inverse of busy. busy is high from the cycle after the miss is taken.
- R3: After a miss is taken, bus_req_valid stays high until a cycle with bus_req_ready high. During that time bus_req_addr equals the miss address with bits [2:0] forced to zero, and it holds steady.
- R4: beat_ready is high only after the burst request has been accepted and before the fourth beat. A beat counts only in a cycle where beat_valid and beat_ready are both high. Cycles with beat_valid low between beats change nothing.
- R5: For the k-th accepted beat (k = 0..3), wr_idx equals (miss_addr[4:3] + k) mod 4.
- R6: In the same cycle a beat is accepted, wr_en is high and wr_data equals beat_data. wr_en is low in every other cycle.
- R7: crit_valid is high only in the cycle of the first accepted beat. In that cycle crit_data equals that beat's data.
- R8: Exactly four beats are accepted per fill. fill_done is high for one cycle, the cycle after the fourth beat, and busy is still high then. busy is low in the cycle after fill_done.
- R9: While fill_done is high, line_data bits [64*i+63:64*i] hold the beat that was written with wr_idx = i, for i = 0..3. This is address order, not arrival order.
- R10: While busy is high, miss_valid has no effect. No second fill starts, and bus_req_addr keeps the first miss's address.
- R11: Asserting reset during a fill drops the fill. busy and beat_ready go low at once, and no fill_done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Miss request ready (no fill active) |
| miss_addr | input | ADDR_W | Missing byte address |
| bus_req_valid | output | 1 | Burst read request valid |
| bus_req_ready | input | 1 | Burst read request accepted |
| bus_req_addr | output | ADDR_W | Address of the critical double word |
| beat_valid | input | 1 | Read beat valid |
| beat_ready | output | 1 | Block can take a read beat |
| beat_data | input | BUS_W | Read beat data |
| wr_en | output | 1 | Cache data write strobe |
| wr_idx | output | IDX_W | Double-word slot within the line |
| wr_data | output | BUS_W | Data written to the slot |
| crit_valid | output | 1 | Critical double word forwarded |
| crit_data | output | BUS_W | Critical double word for the requester |
| busy | output | 1 | Fill in progress; new cache accesses blocked |
| fill_done | output | 1 | One-cycle completion pulse |
| line_data | output | BUS_W*BEATS | Assembled line in address order |

## Verification
The bound checker watches several rules on every cycle:
- the wrapping slot sequence and the four-beat count, tracked by its own counter seeded from the accepted miss address;
- request hold while bus_req_ready is low;
- writes occurring only on accepted beats;
- the critical strobe appearing only on the first write;
- the single-cycle completion pulse with busy still high.

Other behaviours can only be shown by the bench's scenarios. These are the data contents of the line buffer in address order, the absence of effect from misses during a fill, the dropped fill after a mid-burst reset, and behaviour under varied stall patterns and critical offsets.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BEAT = 2'd2,
    ST_DONE = 2'd3
  } fill_state_e;
endpackage

// File: rtl/lfill_seq.sv
module lfill_seq
  import lfill_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_fire,
  input  logic             req_fire,
  input  logic             beat_fire,
  output fill_state_e      state,
  output logic [IDX_W-1:0] beat_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (miss_fire) state <= ST_REQ;
        ST_REQ: if (req_fire) begin
          state    <= ST_BEAT;
          beat_cnt <= '0;
        end
        ST_BEAT: if (beat_fire) begin
          beat_cnt <= beat_cnt + 1'b1;
          if (beat_cnt == LAST) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfill_idx.sv
module lfill_idx #(
  parameter int ADDR_W = 32,
  parameter int BOFF   = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [IDX_W-1:0]  beat_cnt,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  slot
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (capture) addr_q <= miss_addr;
  end

  always_comb begin
    req_addr = addr_q;
    req_addr[BOFF-1:0] = '0;
    slot = addr_q[BOFF +: IDX_W] + beat_cnt;
  end
endmodule

// File: rtl/lfill_linebuf.sv
module lfill_linebuf #(
  parameter int BUS_W = 64,
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [BUS_W-1:0]       din,
  output logic [BUS_W*BEATS-1:0] line
);
  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [BUS_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (we && idx == IDX_W'(g)) slot_q <= din;
    end
    assign line[g*BUS_W +: BUS_W] = slot_q;
  end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BUS_W      = 64,
  localparam int BEATS     = LINE_WORDS * WORD_W / BUS_W,
  localparam int IDX_W     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_BITS = BUS_W * BEATS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_valid,
  output logic                 miss_ready,
  input  logic [ADDR_W-1:0]    miss_addr,
  output logic                 bus_req_valid,
  input  logic                 bus_req_ready,
  output logic [ADDR_W-1:0]    bus_req_addr,
  input  logic                 beat_valid,
  output logic                 beat_ready,
  input  logic [BUS_W-1:0]     beat_data,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [BUS_W-1:0]     wr_data,
  output logic                 crit_valid,
  output logic [BUS_W-1:0]     crit_data,
  output logic                 busy,
  output logic                 fill_done,
  output logic [LINE_BITS-1:0] line_data
);
  localparam int BOFF = $clog2(BUS_W / 8);

  fill_state_e      state;
  logic [IDX_W-1:0] beat_cnt;
  logic             miss_fire, req_fire, beat_fire;

  assign miss_ready    = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign bus_req_valid = (state == ST_REQ);
  assign beat_ready    = (state == ST_BEAT);
  assign fill_done     = (state == ST_DONE);

  assign miss_fire = miss_valid & miss_ready;
  assign req_fire  = bus_req_valid & bus_req_ready;
  assign beat_fire = beat_valid & beat_ready;

  assign wr_en      = beat_fire;
  assign wr_data    = beat_data;
  assign crit_valid = beat_fire && (beat_cnt == '0);
  assign crit_data  = beat_data;

  lfill_seq #(.BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_fire (miss_fire),
    .req_fire  (req_fire),
    .beat_fire (beat_fire),
    .state     (state),
    .beat_cnt  (beat_cnt)
  );

  lfill_idx #(.ADDR_W(ADDR_W), .BOFF(BOFF), .IDX_W(IDX_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (miss_fire),
    .miss_addr (miss_addr),
    .beat_cnt  (beat_cnt),
    .req_addr  (bus_req_addr),
    .slot      (wr_idx)
  );

  lfill_linebuf #(.BUS_W(BUS_W), .BEATS(BEATS)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .idx   (wr_idx),
    .din   (wr_data),
    .line  (line_data)
  );
endmodule

// File: rtl/lfill_chk.sv
module lfill_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int BEATS  = 4,
  parameter int BOFF   = 3,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [BUS_W-1:0]  beat_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [BUS_W-1:0]  wr_data,
  input logic              crit_valid,
  input logic              busy,
  input logic              fill_done
);
  logic [IDX_W-1:0] base_q;
  logic [IDX_W:0]   nwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      nwr_q  <= '0;
    end else if (miss_valid && miss_ready) begin
      base_q <= miss_addr[BOFF +: IDX_W];
      nwr_q  <= '0;
    end else if (wr_en) begin
      nwr_q <= nwr_q + 1'b1;
    end
  end

  assert_take_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> busy);
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_ready);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr));
  assert_write_on_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> beat_valid && beat_ready && wr_data == beat_data);
  assert_no_ready_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !beat_ready);
  assert_slot_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == base_q + nwr_q[IDX_W-1:0]);
  assert_crit_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> wr_en && nwr_q == '0);
  assert_four_beats_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> busy && nwr_q == (IDX_W+1)'(BEATS));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done && !busy);
endmodule

bind line_fill_ctrl lfill_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BEATS(BEATS), .BOFF(BOFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_addr(miss_addr), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_addr(bus_req_addr), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_data(beat_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .crit_valid(crit_valid), .busy(busy), .fill_done(fill_done)
);

// File: tb/sim_line_fill_ctrl.sv
module sim_line_fill_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0, bus_req_ready = 1'b0, beat_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [63:0] beat_data = '0;
  logic miss_ready, bus_req_valid, beat_ready, wr_en, crit_valid, busy, fill_done;
  logic [31:0] bus_req_addr;
  logic [1:0] wr_idx;
  logic [63:0] wr_data, crit_data;
  logic [255:0] line_data;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  line_fill_ctrl u0 (.*);

  // {address, stall mask per beat, request delay}
  localparam logic [37:0] VEC [6] = '{
    {32'h0000_1004, 4'b0000, 2'd0},
    {32'h0000_20AC, 4'b0000, 2'd1},
    {32'h1234_5670, 4'b1010, 2'd2},
    {32'hFFFF_FFF9, 4'b0101, 2'd0},
    {32'h0000_0000, 4'b1111, 2'd3},
    {32'h8000_00F3, 4'b0110, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a, input int j);
    return {a[31:5], 5'b0, 32'h5EED_0000 + 32'(j) * 32'h111};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [3:0] stall, input int dly, input bit poke);
    logic [1:0] crit;
    logic [255:0] exp_line;
    crit = a[4:3];
    miss_valid = 1'b1; miss_addr = a;
    #1 chk(miss_ready == 1'b1, "R2 ready when idle", 256'(miss_ready), 1);
    tick();
    miss_valid = poke; miss_addr = a ^ 32'h0000_0018;
    #1 chk(busy == 1'b1 && miss_ready == 1'b0, "R2 busy after take", 256'(busy), 1);
    for (int d = 0; d < dly; d++) begin
      #1 chk(bus_req_valid && bus_req_addr == {a[31:3], 3'b0}, "R3 request held",
             256'(bus_req_addr), 256'({a[31:3], 3'b0}));
      chk(!beat_ready && !wr_en, "R4 no beat before request", 256'(beat_ready), 0);
      tick();
    end
    bus_req_ready = 1'b1;
    #1 chk(bus_req_valid && bus_req_addr == {a[31:3], 3'b0}, "R3 R10 request address",
           256'(bus_req_addr), 256'({a[31:3], 3'b0}));
    tick();
    bus_req_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ix;
      ix = crit + 2'(k);
      if (stall[k]) begin
        beat_valid = 1'b0;
        #1 chk(beat_ready && !wr_en && !crit_valid, "R4 stall no write", 256'(wr_en), 0);
        tick();
      end
      beat_valid = 1'b1; beat_data = pat(a, int'(ix));
      #1 chk(wr_en && wr_idx == ix, "R5 wrap slot", 256'(wr_idx), 256'(ix));
      chk(wr_data == pat(a, int'(ix)), "R6 write data", 256'(wr_data), 256'(pat(a, int'(ix))));
      chk(crit_valid == (k == 0), "R7 crit strobe", 256'(crit_valid), 256'(k == 0));
      if (k == 0) chk(crit_data == pat(a, int'(ix)), "R7 crit data", 256'(crit_data), 256'(pat(a, int'(ix))));
      chk(!fill_done, "R8 no early done", 256'(fill_done), 0);
      tick();
      beat_valid = 1'b0;
    end
    if (poke) miss_valid = 1'b0;
    for (int j = 0; j < 4; j++) exp_line[j*64 +: 64] = pat(a, j);
    #1 chk(fill_done && busy && !beat_ready, "R8 done pulse busy", 256'({fill_done, busy}), 3);
    chk(line_data == exp_line, "R9 line order", line_data, exp_line);
    tick();
    #1 chk(!fill_done && !busy && !bus_req_valid, "R8 R10 idle after done", 256'({fill_done, busy}), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1 chk(!busy && miss_ready && !bus_req_valid && !beat_ready && !wr_en && !crit_valid && !fill_done,
           "R1 reset state", 256'({busy, miss_ready, fill_done}), 256'(3'b010));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VEC[v]) do_fill(VEC[v][37:6], VEC[v][5:2], int'(VEC[v][1:0]), v % 2 == 1);

    // R11: reset in the middle of a burst drops it
    miss_valid = 1'b1; miss_addr = 32'h0000_4010;
    tick();
    miss_valid = 1'b0; bus_req_ready = 1'b1;
    tick();
    bus_req_ready = 1'b0; beat_valid = 1'b1; beat_data = 64'hDEAD;
    tick();
    beat_valid = 1'b0;
    rst_n = 1'b0;
    #1 chk(!busy && !beat_ready && miss_ready, "R11 reset drops fill", 256'({busy, beat_ready}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1 chk(!fill_done && !busy, "R11 no done after reset", 256'(fill_done), 0);
      @(negedge clk);
    end
    do_fill(32'h0000_7018, 4'b0001, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule